// File: doc/BRIEF.md
# Multiplexed-Address DRAM Array Model

This block is a synthesizable behavioural model of a small dynamic memory device. Its storage is a square grid of supercells, each `DATA_W` bits wide, with `2**ADDR_W` rows and `2**ADDR_W` columns. The default is a 4 x 4 grid of 8-bit supercells, so 16 supercells in total. A narrow address bus, `ADDR_W` bits wide, is time-shared. It first carries a row number, which the row strobe captures. It then carries a column number, which the column strobe captures.

A row strobe copies the whole addressed row into an internal row buffer and marks that row as open. Column strobes then work on the row buffer. A read returns one supercell on the data output. A write updates the supercell in the buffer and, in the same edge, in the grid itself. A single open row can serve any number of column strobes in a row without being loaded again. A column strobe that arrives while no row is open is refused and reported with a one-cycle error pulse.

The strobes and `wr_en` are device pins and are sampled on every rising clock edge. The read port has a valid flag and no ready input, so there is no back-pressure. Once a read result appears, it stays on `rdata` until the next accepted column strobe, and the consumer may take it at any time before then. Reset closes the open row. It does not clear the contents of the grid.

Top module: `dram_mux_array`

## Requirements
- R1: While reset is asserted and after it is released, `rd_valid` is 0, `err` is 0 and `rdata` is 0. No row is open after reset, so the first column strobe after reset is refused.
- R2: A row strobe, sampled with row index `r` on `addr`, opens row `r` in the next cycle. It loads every supercell of that row from the grid into the row buffer.
- R3: A column strobe with `wr_en` = 0 and column index `c` on `addr`, made while a row is open, puts supercell (open row, `c`) on `rdata` one clock after the strobe is sampled. `rd_valid` is 1 in that same cycle.
- R4: Column strobes may be issued on consecutive cycles after a single row strobe, in any column order. Each one returns its own supercell from the open row without a further row strobe.
- R5: A column strobe with `wr_en` = 1 writes `wdata` into the selected supercell of the row buffer and of the grid. A later read of the same row returns the new value, and so does a read after that row has been closed and reopened.
- R6: A column strobe made while no row is open is ignored: `rdata` and `rd_valid` keep their values, the grid is unchanged, and `err` is 1 for exactly one cycle.
- R7: After a read, `rdata` and `rd_valid` = 1 hold steady through idle cycles and through row strobes, until the next accepted column strobe.
- R8: When the row strobe and the column strobe are sampled in the same cycle, the row strobe wins and opens the row given on `addr`. The column strobe is refused: `err` pulses for one cycle and `rdata` is unchanged.
- R9: An accepted write column strobe clears `rd_valid` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (2) | Shared bus: row index with `row_stb`, column index with `col_stb` |
| row_stb | input | 1 | Row strobe: open the row on `addr` |
| col_stb | input | 1 | Column strobe: access the supercell on `addr` in the open row |
| wr_en | input | 1 | With `col_stb`: 1 writes `wdata`, 0 reads |
| wdata | input | DATA_W (8) | Write data |
| rdata | output | DATA_W (8) | Read data, held until the next accepted column strobe |
| rd_valid | output | 1 | `rdata` holds the result of the most recent read |
| err | output | 1 | One-cycle pulse for a refused column strobe |

## Verification
The assertions assume that the strobes, `addr`, `wr_en` and `wdata` are stable, known values around each rising edge. They also assume that the grid is read only at supercells written since power-up, because reset does not clear the grid. The stimulus changes every input one nanosecond after a rising edge. It fills all sixteen supercells with writes before it issues any read. It drives the illegal orderings on purpose: a column strobe before any row strobe, a column strobe right after a reset, and both strobes together, so that the refusal paths are exercised.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;
  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_OPEN,
    ACC_READ,
    ACC_WRITE
  } acc_kind_e;
endpackage

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
  import dram_mux_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_stb,
  input  logic              col_stb,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic              row_open,
  output logic [ADDR_W-1:0] open_row,
  output logic              err
);
  logic reject;

  always_comb begin
    reject = col_stb && (row_stb || !row_open);
    if (row_stb)
      kind = ACC_OPEN;
    else if (col_stb && row_open)
      kind = wr_en ? ACC_WRITE : ACC_READ;
    else
      kind = ACC_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_open <= 1'b0;
      open_row <= '0;
      err      <= 1'b0;
    end else begin
      err <= reject;
      if (row_stb) begin
        row_open <= 1'b1;
        open_row <= addr;
      end
    end
  end

  // R2: a row strobe leaves the addressed row open
  assert_row_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    row_stb |=> row_open && open_row == $past(addr));

  // R6: a column strobe with no row open is flagged
  assert_closed_col_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (col_stb && !row_stb && !row_open) |=> err);

  // R8: both strobes together open the row and flag the column
  assert_dual_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (row_stb && col_stb) |=> (err && row_open));
endmodule

// File: rtl/dram_cell_grid.sv
module dram_cell_grid #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            rd_row,
  input  logic                         we,
  input  logic [ADDR_W-1:0]            wr_row,
  input  logic [ADDR_W-1:0]            wr_col,
  input  logic [DATA_W-1:0]            wdata,
  output logic [(2**ADDR_W)*DATA_W-1:0] row_data
);
  localparam int ROWS = 2 ** ADDR_W;
  localparam int COLS = 2 ** ADDR_W;

  logic [DATA_W-1:0] cells [ROWS][COLS];

  for (genvar c = 0; c < COLS; c++) begin : g_row_tap
    assign row_data[c*DATA_W +: DATA_W] = cells[rd_row][c];
  end

  always_ff @(posedge clk) begin
    if (we) cells[wr_row][wr_col] <= wdata;
  end

  // R5: a write lands in the grid at the open row and the selected column
  assert_write_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> cells[$past(wr_row)][$past(wr_col)] == $past(wdata));
endmodule

// File: rtl/dram_row_latch.sv
module dram_row_latch
  import dram_mux_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  acc_kind_e                     kind,
  input  logic [ADDR_W-1:0]             col,
  input  logic [(2**ADDR_W)*DATA_W-1:0] row_data,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  output logic                          rd_valid
);
  localparam int COLS = 2 ** ADDR_W;

  logic [DATA_W-1:0] line [COLS];

  always_ff @(posedge clk) begin
    if (kind == ACC_OPEN) begin
      for (int c = 0; c < COLS; c++) line[c] <= row_data[c*DATA_W +: DATA_W];
    end else if (kind == ACC_WRITE) begin
      line[col] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else if (kind == ACC_READ) begin
      rdata    <= line[col];
      rd_valid <= 1'b1;
    end else if (kind == ACC_WRITE) begin
      rd_valid <= 1'b0;
    end
  end

  // R3: a read produces valid data on the next cycle
  assert_read_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_READ) |=> rd_valid);

  // R9: a write drops the valid flag
  assert_write_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_WRITE) |=> !rd_valid);

  // R7: read data holds until the next accepted column access
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && kind != ACC_READ && kind != ACC_WRITE) |=> (rd_valid && $stable(rdata)));
endmodule

// File: rtl/dram_mux_array.sv
module dram_mux_array
  import dram_mux_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              row_stb,
  input  logic              col_stb,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  output logic              err
);
  localparam int ROW_BITS = (2 ** ADDR_W) * DATA_W;

  acc_kind_e           kind;
  logic                row_open;
  logic [ADDR_W-1:0]   open_row;
  logic [ROW_BITS-1:0] row_data;

  dram_strobe_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .row_stb  (row_stb),
    .col_stb  (col_stb),
    .wr_en    (wr_en),
    .addr     (addr),
    .kind     (kind),
    .row_open (row_open),
    .open_row (open_row),
    .err      (err)
  );

  dram_cell_grid #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_grid (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_row   (addr),
    .we       (kind == ACC_WRITE),
    .wr_row   (open_row),
    .wr_col   (addr),
    .wdata    (wdata),
    .row_data (row_data)
  );

  dram_row_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .kind     (kind),
    .col      (addr),
    .row_data (row_data),
    .wdata    (wdata),
    .rdata    (rdata),
    .rd_valid (rd_valid)
  );

  // R6: a refused column strobe leaves the read port untouched
  assert_reject_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(rdata) && $stable(rd_valid)));
endmodule

// File: tb/dram_mux_array_tb.sv
module dram_mux_array_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       row_stb = 1'b0;
  logic       col_stb = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rd_valid;
  logic       err;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q [$];
  logic due_q = 1'b0;

  always #2.5 clk = ~clk;

  dram_mux_array u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .row_stb(row_stb), .col_stb(col_stb),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .err(err)
  );

  function automatic logic [7:0] pat(input int r, input int c);
    return 8'((r * 16 + c) ^ 8'hA5);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic rs, input logic cs, input logic we,
                     input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    row_stb = rs; col_stb = cs; wr_en = we; addr = a; wdata = d;
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 1'b0, 2'd0, 8'd0);
  endtask

  task automatic open_r(input int r);
    cyc(1'b1, 1'b0, 1'b0, 2'(r), 8'd0);
  endtask

  task automatic wr(input int c, input logic [7:0] d);
    cyc(1'b0, 1'b1, 1'b1, 2'(c), d);
  endtask

  task automatic rd(input int c, input logic [7:0] exp);
    cyc(1'b0, 1'b1, 1'b0, 2'(c), 8'd0);
    exp_q.push_back(exp);
  endtask

  // scoreboard monitor: R3/R4 read results
  always @(posedge clk) due_q <= (exp_q.size() != 0);

  always @(negedge clk) begin
    if (due_q) begin
      logic [7:0] e;
      e = exp_q.pop_front();
      chk("R3 R4 read data", 32'(rdata), 32'(e));
      chk("R3 read valid", 32'(rd_valid), 32'd1);
    end
  end

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] held;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 rd_valid in reset", 32'(rd_valid), 32'd0);
    chk("R1 err in reset", 32'(err), 32'd0);
    chk("R1 rdata in reset", 32'(rdata), 32'd0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rd_valid after reset", 32'(rd_valid), 32'd0);

    // R6: column strobe before any row strobe
    rd(1, 8'h00); void'(exp_q.pop_back());
    idle();
    @(negedge clk);
    chk("R6 err pulse", 32'(err), 32'd1);
    chk("R6 rdata untouched", 32'(rdata), 32'd0);
    chk("R6 rd_valid untouched", 32'(rd_valid), 32'd0);
    @(negedge clk);
    chk("R6 err one cycle", 32'(err), 32'd0);

    // R5: fill the grid through the row buffer
    for (int r = 0; r < 4; r++) begin
      open_r(r);
      for (int c = 0; c < 4; c++) wr(c, pat(r, c));
    end
    idle();
    @(negedge clk);
    chk("R9 valid low after writes", 32'(rd_valid), 32'd0);

    // R2/R4: each row opened once, columns read back to back in mixed order
    for (int r = 3; r >= 0; r--) begin
      open_r(r);
      rd(3, pat(r, 3)); rd(0, pat(r, 0)); rd(2, pat(r, 2)); rd(1, pat(r, 1));
    end
    idle();

    // R7: data holds through idle cycles and a row strobe
    @(negedge clk);
    held = rdata;
    chk("R7 last read value", 32'(held), 32'(pat(0, 1)));
    open_r(2);
    idle();
    repeat (2) @(negedge clk);
    chk("R7 rdata held", 32'(rdata), 32'(held));
    chk("R7 rd_valid held", 32'(rd_valid), 32'd1);

    // R8: both strobes together, row wins
    cyc(1'b1, 1'b1, 1'b0, 2'd1, 8'd0);
    idle();
    @(negedge clk);
    chk("R8 err pulse", 32'(err), 32'd1);
    chk("R8 rdata untouched", 32'(rdata), 32'(held));
    rd(3, pat(1, 3));
    idle();
    @(negedge clk);
    chk("R8 err cleared", 32'(err), 32'd0);

    // R5: write-through visible in buffer and after reopening
    open_r(1);
    wr(2, 8'h3C);
    rd(2, 8'h3C);
    wr(0, 8'hC3);
    idle();
    @(negedge clk);
    chk("R9 write clears valid", 32'(rd_valid), 32'd0);
    open_r(3);
    rd(2, pat(3, 2));
    open_r(1);
    rd(2, 8'h3C);
    rd(0, 8'hC3);
    rd(1, pat(1, 1));
    idle();
    repeat (2) @(negedge clk);

    // R1: reset mid-run closes the row
    @(posedge clk); #1; rst_n = 1'b0;
    @(negedge clk);
    chk("R1 rd_valid cleared by reset", 32'(rd_valid), 32'd0);
    chk("R1 rdata cleared by reset", 32'(rdata), 32'd0);
    @(posedge clk); #1; rst_n = 1'b1;
    cyc(1'b0, 1'b1, 1'b0, 2'd2, 8'd0);
    idle();
    @(negedge clk);
    chk("R1 no open row after reset", 32'(err), 32'd1);
    chk("R6 ignored after reset", 32'(rd_valid), 32'd0);

    // R5: grid kept its contents through reset
    open_r(1);
    rd(2, 8'h3C);
    rd(3, pat(1, 3));
    idle();
    repeat (3) @(negedge clk);
    chk("R4 scoreboard drained", 32'(exp_q.size()), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule